// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Port

This block adapts a 16-bit network controller to system memory. The controller issues a request made of an address, a byte length, a direction and a bypass flag. The port places a fixed upper base over that address with a bitwise OR, then moves the data one 16-bit halfword per memory beat. The controller supplies write data through a small stream, and read data comes back through a strobed output.

When the bypass flag is clear, the port is in swap mode. It forces the address and the length to even values and exchanges the two bytes of every halfword in both directions. In swap mode, memory writes are also cut into bursts of a bounded size. A one-cycle completion pulse closes every request, including requests that need no memory traffic at all.

Top module: `hwswap_port`

## Requirements
- R1: The first memory beat address is `reqAddr | baseAddr`, sampled when the request is accepted. In swap mode, bit 0 is then also cleared.
- R2: With `reqBypass`=1, the address is used unaligned and the data passes unchanged in both directions. The beat count is ceil(`reqLen`/2).
- R3: With `reqBypass`=0, address bit 0 and length bit 0 are treated as zero. The beat count is floor(`reqLen`/2).
- R4: With `reqBypass`=0, every halfword is byte-exchanged: `memWData` = {`wrData`[7:0], `wrData`[15:8]} on writes, and `rdData` = {`memRData`[7:0], `memRData`[15:8]} on reads.
- R5: `memAddr` rises by 2 after every beat handshake (`memValid && memReady`). It holds while a beat is stalled.
- R6: In swap mode, a write is cut into chunks of 32 beats (64 bytes), and `memFirst`=1 on the first beat of each chunk. Reads and bypass transfers form one chunk, so `memFirst` is high only on their first beat.
- R7: `done` is high for exactly one cycle, in the cycle after the handshake of the last beat.
- R8: A request of zero beats, including a swap request of length 1, causes no `memValid`. `done` rises in the cycle after acceptance.
- R9: `reqReady` is high only while idle. Requests offered while a transfer runs are ignored and do not disturb the address sequence.
- R10: Reset sets the port idle: `reqReady`=1, `memValid`=0, `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baseAddr | input | 32 | Upper base ORed into every request address |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Port idle, request accepted this cycle |
| reqAddr | input | 32 | Request byte address |
| reqLen | input | 16 | Request length in bytes |
| reqWrite | input | 1 | 1 = write memory, 0 = read memory |
| reqBypass | input | 1 | 1 = no alignment or byte swap |
| wrValid | input | 1 | Write halfword available |
| wrReady | output | 1 | Write halfword consumed |
| wrData | input | 16 | Write halfword from controller |
| rdValid | output | 1 | Read halfword valid |
| rdData | output | 16 | Read halfword to controller |
| memValid | output | 1 | Memory beat request |
| memReady | input | 1 | Memory accepts beat |
| memWrite | output | 1 | Beat direction |
| memFirst | output | 1 | First beat of a chunk |
| memAddr | output | 32 | Beat byte address |
| memWData | output | 16 | Beat write data |
| memRData | input | 16 | Beat read data, valid during handshake |
| done | output | 1 | Request complete pulse |

## Verification
The first memory beat appears in the cycle after the request is accepted. Within a beat cycle, every data, address and strobe output is combinational from the inputs, so `rdData` and `wrReady` follow the memory handshake in the same cycle. `done` follows one cycle after the last handshake. For zero-beat requests, `done` follows one cycle after acceptance. The bench drives inputs on the falling edge, waits one time unit, and samples before the next rising edge, so each check lands in the exact cycle its result is due. Stalled beats are checked in both stall cycles so that a held address is seen.

// File: rtl/hwswap_pkg.sv
package hwswap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } portState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // request accepted: capture address and mode
    logic step;   // beat handshake: advance address
  } dpCtrl_t;

  function automatic logic [15:0] swapHalf(input logic [15:0] d, input logic en);
    return en ? {d[7:0], d[15:8]} : d;
  endfunction

endpackage

// File: rtl/hwswap_ctrl.sv
module hwswap_ctrl
  import hwswap_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             reqWrite,
  input  logic             reqBypass,
  input  logic             wrValid,
  input  logic             memReady,
  output logic             reqReady,
  output logic             wrReady,
  output logic             rdValid,
  output logic             memValid,
  output logic             memWrite,
  output logic             memFirst,
  output logic             done,
  output dpCtrl_t          dpCtl
);

  localparam int CHUNK_BEATS = CHUNK_BYTES / 2;
  localparam int CNT_W       = (CHUNK_BEATS > 1) ? $clog2(CHUNK_BEATS) : 1;

  portState_t       state;
  logic [LEN_W-1:0] remain;
  logic [CNT_W-1:0] chunkCnt;
  logic             wrMode;
  logic             splitMode;
  logic             firstFlag;

  logic [LEN_W:0]   lenPlus;
  logic [LEN_W-1:0] beatsIn;
  logic             accept;
  logic             beat;

  assign lenPlus = {1'b0, reqLen} + {{LEN_W{1'b0}}, 1'b1};
  assign beatsIn = reqBypass ? lenPlus[LEN_W:1] : {1'b0, reqLen[LEN_W-1:1]};

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign memValid = (state == ST_RUN) && (!wrMode || wrValid);
  assign beat     = memValid && memReady;
  assign wrReady  = (state == ST_RUN) && wrMode && memReady;
  assign rdValid  = beat && !wrMode;
  assign memWrite = wrMode;
  assign memFirst = firstFlag && (state == ST_RUN);
  assign done     = (state == ST_FIN);

  assign dpCtl.load = accept;
  assign dpCtl.step = beat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remain    <= '0;
      chunkCnt  <= '0;
      wrMode    <= 1'b0;
      splitMode <= 1'b0;
      firstFlag <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          wrMode    <= reqWrite;
          splitMode <= reqWrite && !reqBypass;
          remain    <= beatsIn;
          chunkCnt  <= '0;
          firstFlag <= 1'b1;
          state     <= (beatsIn == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (beat) begin
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1)) state <= ST_FIN;
          if (splitMode && chunkCnt == CNT_W'(CHUNK_BEATS - 1)) begin
            chunkCnt  <= '0;
            firstFlag <= 1'b1;
          end else begin
            chunkCnt  <= chunkCnt + 1'b1;
            firstFlag <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hwswap_dp.sv
module hwswap_dp
  import hwswap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              reqBypass,
  input  logic [15:0]       wrData,
  input  logic [15:0]       memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWData,
  output logic [15:0]       rdData
);

  logic [ADDR_W-1:0] addrReg;
  logic              bypassReg;
  logic [ADDR_W-1:0] alignMask;

  assign alignMask = {{(ADDR_W-1){1'b1}}, reqBypass};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      bypassReg <= 1'b0;
    end else if (dpCtl.load) begin
      addrReg   <= (reqAddr | baseAddr) & alignMask;
      bypassReg <= reqBypass;
    end else if (dpCtl.step) begin
      addrReg <= addrReg + ADDR_W'(2);
    end
  end

  assign memAddr  = addrReg;
  assign memWData = swapHalf(wrData, !bypassReg);
  assign rdData   = swapHalf(memRData, !bypassReg);

endmodule

// File: rtl/hwswap_port.sv
module hwswap_port
  import hwswap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic              reqBypass,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [15:0]       wrData,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic              memFirst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWData,
  input  logic [15:0]       memRData,
  output logic              done
);

  dpCtrl_t dpCtl;

  hwswap_ctrl #(.LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .reqWrite(reqWrite), .reqBypass(reqBypass), .wrValid(wrValid),
    .memReady(memReady), .reqReady(reqReady), .wrReady(wrReady),
    .rdValid(rdValid), .memValid(memValid), .memWrite(memWrite),
    .memFirst(memFirst), .done(done), .dpCtl(dpCtl)
  );

  hwswap_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .reqAddr(reqAddr),
    .baseAddr(baseAddr), .reqBypass(reqBypass), .wrData(wrData),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData),
    .rdData(rdData)
  );

endmodule

// File: rtl/hwswap_port_chk.sv
module hwswap_port_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done
);

  // R5
  step_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (memAddr == $past(memAddr) + ADDR_W'(2)));

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(memValid && memReady) && !(reqValid && reqReady)) |=> $stable(memAddr));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memValid);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady);

endmodule

bind hwswap_port hwswap_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .memValid(memValid), .memReady(memReady), .memAddr(memAddr), .done(done)
);

// File: tb/hwswap_port_bench.sv
module hwswap_port_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic        wr;
    logic        byp;
    logic [31:0] base;
    logic        stall;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0100, 16'd8,  1'b1, 1'b0, 32'hFF00_0000, 1'b0},
    '{32'h0000_0101, 16'd7,  1'b0, 1'b0, 32'h0000_0000, 1'b0},
    '{32'h0000_0203, 16'd5,  1'b1, 1'b1, 32'h0000_0000, 1'b0},
    '{32'h0000_0040, 16'd70, 1'b1, 1'b0, 32'h0100_0000, 1'b0},
    '{32'h0000_0010, 16'd70, 1'b0, 1'b0, 32'h0000_0000, 1'b1},
    '{32'h0000_0000, 16'd1,  1'b1, 1'b0, 32'h0000_0000, 1'b0},
    '{32'h0000_0000, 16'd0,  1'b0, 1'b1, 32'h0000_0000, 1'b0},
    '{32'h0000_0020, 16'd64, 1'b1, 1'b0, 32'h0000_0010, 1'b0},
    '{32'h0000_0011, 16'd66, 1'b1, 1'b1, 32'h0000_0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] baseAddr = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic        reqWrite = 1'b0;
  logic        reqBypass = 1'b0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [15:0] wrData = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic        memValid;
  logic        memReady = 1'b1;
  logic        memWrite;
  logic        memFirst;
  logic [31:0] memAddr;
  logic [15:0] memWData;
  logic [15:0] memRData = '0;
  logic        done;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwswap_port u_hwswap_port (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqWrite(reqWrite), .reqBypass(reqBypass), .wrValid(wrValid),
    .wrReady(wrReady), .wrData(wrData), .rdValid(rdValid), .rdData(rdData),
    .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memFirst(memFirst), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int k);
    return {8'(k * 3 + 8'h11), 8'(k * 7 + 8'h40)};
  endfunction

  task automatic runVec(input vec_t v);
    int beats;
    logic [31:0] a0;
    logic [15:0] src;
    logic [15:0] expD;
    beats = v.byp ? (int'(v.len) + 1) / 2 : int'(v.len) / 2;
    a0 = (v.addr | v.base) & (v.byp ? 32'hFFFF_FFFF : 32'hFFFF_FFFE);
    @(negedge clk);
    baseAddr = v.base; reqAddr = v.addr; reqLen = v.len;
    reqWrite = v.wr; reqBypass = v.byp; reqValid = 1'b1;
    wrValid = 1'b0; memReady = 1'b1;
    #1 chk(reqReady == 1'b1, "R9 idle ready", 32'(reqReady), 32'd1);
    @(posedge clk);
    for (int k = 0; k < beats; k++) begin
      @(negedge clk);
      // junk request while busy must be ignored (R9)
      reqValid = 1'b1; reqAddr = 32'hDEAD_0000; reqLen = 16'd2;
      reqBypass = ~v.byp; baseAddr = 32'h00F0_0000;
      src = pat(k);
      wrValid = v.wr; wrData = src; memRData = src;
      expD = v.byp ? src : {src[7:0], src[15:8]};
      if (v.stall && (k % 2 == 1)) begin
        memReady = 1'b0;
        #1 chk(memValid == 1'b1, "R5 stalled valid", 32'(memValid), 32'd1);
        chk(memAddr == a0 + 32'(2 * k), "R5 stalled addr", memAddr, a0 + 32'(2 * k));
        @(negedge clk);
      end
      memReady = 1'b1;
      #1;
      chk(memValid == 1'b1, "R7 beat valid", 32'(memValid), 32'd1);
      chk(reqReady == 1'b0, "R9 busy ready", 32'(reqReady), 32'd0);
      if (k == 0) begin
        chk(memAddr == a0, "R1 first addr", memAddr, a0);
        chk(memAddr[0] == (v.byp & a0[0]), v.byp ? "R2 unaligned" : "R3 aligned",
            32'(memAddr[0]), 32'(v.byp & a0[0]));
      end else begin
        chk(memAddr == a0 + 32'(2 * k), "R5 addr step", memAddr, a0 + 32'(2 * k));
      end
      chk(memFirst == ((k == 0) || (v.wr && !v.byp && (k % 32 == 0))), "R6 chunk start",
          32'(memFirst), 32'((k == 0) || (v.wr && !v.byp && (k % 32 == 0))));
      if (v.wr) begin
        chk(wrReady == 1'b1, "R4 write ready", 32'(wrReady), 32'd1);
        chk(memWData == expD, v.byp ? "R2 write data" : "R4 write swap", 32'(memWData), 32'(expD));
      end else begin
        chk(rdValid == 1'b1, "R4 read valid", 32'(rdValid), 32'd1);
        chk(rdData == expD, v.byp ? "R2 read data" : "R4 read swap", 32'(rdData), 32'(expD));
      end
    end
    @(negedge clk);
    reqValid = 1'b0; wrValid = 1'b0;
    #1 chk(done == 1'b1, beats == 0 ? "R8 zero done" : "R7 done due", 32'(done), 32'd1);
    chk(memValid == 1'b0, beats == 0 ? "R8 no traffic" : "R7 quiet", 32'(memValid), 32'd0);
    @(negedge clk);
    #1 chk(done == 1'b0, "R7 single pulse", 32'(done), 32'd0);
    chk(reqReady == 1'b1, "R9 ready again", 32'(reqReady), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    // R10 reset state
    chk(reqReady == 1'b1, "R10 reset ready", 32'(reqReady), 32'd1);
    chk(memValid == 1'b0, "R10 reset valid", 32'(memValid), 32'd0);
    chk(done == 1'b0, "R10 reset done", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R10 reset in the middle of a transfer
    @(negedge clk);
    reqAddr = 32'h0000_0400; reqLen = 16'd20; reqWrite = 1'b0;
    reqBypass = 1'b0; baseAddr = '0; reqValid = 1'b1; memReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    #1 chk(memValid == 1'b1, "R10 running", 32'(memValid), 32'd1);
    rstN = 1'b0;
    #1 chk(memValid == 1'b0, "R10 abort valid", 32'(memValid), 32'd0);
    chk(reqReady == 1'b1, "R10 abort ready", 32'(reqReady), 32'd1);
    chk(done == 1'b0, "R10 abort done", 32'(done), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // port must work normally after the abort
    runVec('{32'h0000_0006, 16'd4, 1'b0, 1'b0, 32'h0000_8000, 1'b0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule